// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Aggregator

This block collects inbound message-signalled interrupt writes and turns them into a small set of level interrupt lines for a host interrupt controller. An inbound write that lands on the doorbell offset carries a vector number in its data word. The block records that vector as pending in one of several status groups. Vectors are interleaved across the groups by their low bits, so with the default sizing, group g holds vectors g, g+8, g+16 and g+24. Software finds the vector that fired by scanning the four bits of a group and forming group + 8*bit.

A 32-bit register port gives software three registers per group: a raw pending word that is cleared by writing ones, a write-one-to-set enable register and a write-one-to-clear enable register. It also has one end-of-interrupt register. Each group drives one interrupt line. The line is high while any pending bit of that group is also enabled. An end-of-interrupt write drops the line for one cycle, so that an edge-sensitive controller sees a fresh edge when work is still left.

Neither port applies back-pressure. The inbound write port takes a write on every cycle in which `msi_valid` is high, and the register port takes a request on every cycle in which `csr_valid` is high. A read returns `csr_rvalid` with its data exactly one cycle later, and nothing can stall that response.

Top module: `msi_agg`

## Requirements
- R1: Reset clears every pending bit and every enable bit, and drives `irq_o` and `csr_rvalid` low.
- R2: An inbound write to offset 0x054 with data v below 32 sets bit (v >> 3) of group (v mod 8). Group n's pending word is read at offset 0x104 + 16*n, in bits 3:0.
- R3: An inbound write with data of 32 or more, or at any offset other than 0x054, changes no pending bit and no interrupt line.
- R4: A register write to offset 0x104 + 16*n clears each pending bit of group n whose data bit (3:0) is 1. Pending bits whose data bit is 0 keep their value.
- R5: A write of ones to offset 0x108 + 16*n sets those enable bits of group n, and a write of ones to 0x10C + 16*n clears them. Zero data bits leave the enable unchanged. Reads of either offset return the current enable mask in bits 3:0.
- R6: A read of a pending word returns the raw pending bits whatever the enable mask is.
- R7: `irq_o[n]` is the OR over the four bits of (pending AND enable) of group n. It follows a write on the first clock edge that samples the write.
- R8: A register write to offset 0x050 with data n+4 drives `irq_o[n]` low for exactly one cycle, after which the line returns high if group n still has an enabled pending bit. Any other data value, including 0 to 3, changes no line.
- R9: When an inbound doorbell write and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: `csr_rvalid` is high in the cycle after each read request, and only then, with the read data on `csr_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound write strobe, taken every cycle it is high |
| msi_addr | input | 12 | Inbound write offset |
| msi_data | input | 32 | Inbound write data (vector number) |
| csr_valid | input | 1 | Register request strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Register offset |
| csr_wdata | input | 32 | Register write data |
| csr_rvalid | output | 1 | Read data valid, one cycle after a read |
| csr_rdata | output | 32 | Read data |
| irq_o | output | 8 | One interrupt line per group |

## Verification
Doorbells are sent with vectors from several groups and bit positions, including 0, 7, 13, 24 and 31. Reading the pending words back shows that the interleaving maps each vector to the right group and bit. Out-of-range vectors and wrong offsets are sent next, and the bench then reads every group back to show that nothing moved. Enable writes are made with zero, single-bit and multi-bit masks, and pending words are read while masked. Together these separate the raw pending state from the interrupt line. End-of-interrupt writes with a group code, a reserved code and an out-of-range code show the one-cycle drop and confirm that the line stays put otherwise. A doorbell and a clear aimed at the same bit in the same cycle show that the doorbell wins.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int DOORBELL_OFS = 'h054;
  localparam int EOI_OFS      = 'h050;
  localparam int GRP_BASE     = 'h100;
  localparam int GRP_STRIDE_SH = 4;
  localparam int SUB_STAT     = 'h4;
  localparam int SUB_EN_SET   = 'h8;
  localparam int SUB_EN_CLR   = 'hC;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_STAT  = 2'd1,
    KIND_ENSET = 2'd2,
    KIND_ENCLR = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_agg_pkg::*;
#(
  parameter int N_GROUPS   = 8,
  parameter int GROUP_BITS = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32
) (
  input  logic                                 msi_valid,
  input  logic [ADDR_W-1:0]                    msi_addr,
  input  logic [DATA_W-1:0]                    msi_data,
  output logic [N_GROUPS-1:0][GROUP_BITS-1:0]  set_arr
);
  localparam int NUM_VEC = N_GROUPS * GROUP_BITS;
  localparam int GIW = $clog2(N_GROUPS);
  localparam int BIW = $clog2(GROUP_BITS);

  logic           hit;
  logic [GIW-1:0] grp;
  logic [BIW-1:0] bpos;

  assign hit  = msi_valid && (msi_addr == ADDR_W'(DOORBELL_OFS))
                && (msi_data < DATA_W'(NUM_VEC));
  assign grp  = msi_data[GIW-1:0];
  assign bpos = msi_data[GIW +: BIW];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < GROUP_BITS; b++) begin : g_bit
      assign set_arr[g][b] = hit && (grp == GIW'(g)) && (bpos == BIW'(b));
    end
  end
endmodule

// File: rtl/msi_csr_decode.sv
module msi_csr_decode
  import msi_agg_pkg::*;
#(
  parameter int N_GROUPS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int EOI_BIAS = 4
) (
  input  logic                        csr_valid,
  input  logic                        csr_write,
  input  logic [ADDR_W-1:0]           csr_addr,
  input  logic [DATA_W-1:0]           csr_wdata,
  output logic [N_GROUPS-1:0]         stat_clr_oh,
  output logic [N_GROUPS-1:0]         en_set_oh,
  output logic [N_GROUPS-1:0]         en_clr_oh,
  output logic [N_GROUPS-1:0]         eoi_oh,
  output reg_kind_e                   rd_kind,
  output logic [$clog2(N_GROUPS)-1:0] rd_grp
);
  localparam int GIW = $clog2(N_GROUPS);
  localparam int GRP_END = GRP_BASE + (N_GROUPS << GRP_STRIDE_SH);

  logic           in_grp;
  logic [GIW-1:0] grp;
  logic [3:0]     sub;
  reg_kind_e      kind;
  logic           wr;

  assign wr     = csr_valid && csr_write;
  assign in_grp = (csr_addr >= ADDR_W'(GRP_BASE)) && (csr_addr < ADDR_W'(GRP_END));
  assign grp    = GIW'((csr_addr - ADDR_W'(GRP_BASE)) >> GRP_STRIDE_SH);
  assign sub    = csr_addr[3:0];

  always_comb begin
    kind = KIND_NONE;
    if (in_grp) begin
      unique case (sub)
        4'(SUB_STAT):   kind = KIND_STAT;
        4'(SUB_EN_SET): kind = KIND_ENSET;
        4'(SUB_EN_CLR): kind = KIND_ENCLR;
        default:        kind = KIND_NONE;
      endcase
    end
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_strobe
    logic sel;
    assign sel            = wr && (grp == GIW'(g));
    assign stat_clr_oh[g] = sel && (kind == KIND_STAT);
    assign en_set_oh[g]   = sel && (kind == KIND_ENSET);
    assign en_clr_oh[g]   = sel && (kind == KIND_ENCLR);
    assign eoi_oh[g]      = wr && (csr_addr == ADDR_W'(EOI_OFS))
                            && (csr_wdata == DATA_W'(g + EOI_BIAS));
  end

  assign rd_kind = kind;
  assign rd_grp  = grp;
endmodule

// File: rtl/msi_group.sv
module msi_group #(
  parameter int GROUP_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_BITS-1:0] set_bits,
  input  logic                  clr_we,
  input  logic                  en_set_we,
  input  logic                  en_clr_we,
  input  logic [GROUP_BITS-1:0] wbits,
  input  logic                  eoi,
  output logic [GROUP_BITS-1:0] status_o,
  output logic [GROUP_BITS-1:0] enable_o,
  output logic                  irq_o
);
  logic [GROUP_BITS-1:0] status_q, status_d;
  logic [GROUP_BITS-1:0] enable_q, enable_d;
  logic                  irq_q, irq_d;

  always_comb begin
    // a fresh doorbell overrides a clear of the same bit
    status_d = (status_q & ~(clr_we ? wbits : '0)) | set_bits;
    enable_d = (enable_q | (en_set_we ? wbits : '0)) & ~(en_clr_we ? wbits : '0);
    irq_d    = (|(status_d & enable_d)) && !eoi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/msi_agg.sv
module msi_agg
  import msi_agg_pkg::*;
#(
  parameter int N_GROUPS   = 8,
  parameter int GROUP_BITS = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int EOI_BIAS   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msi_valid,
  input  logic [ADDR_W-1:0]   msi_addr,
  input  logic [DATA_W-1:0]   msi_data,
  input  logic                csr_valid,
  input  logic                csr_write,
  input  logic [ADDR_W-1:0]   csr_addr,
  input  logic [DATA_W-1:0]   csr_wdata,
  output logic                csr_rvalid,
  output logic [DATA_W-1:0]   csr_rdata,
  output logic [N_GROUPS-1:0] irq_o
);
  localparam int GIW = $clog2(N_GROUPS);

  logic [N_GROUPS-1:0][GROUP_BITS-1:0] set_arr;
  logic [N_GROUPS-1:0][GROUP_BITS-1:0] stat_arr;
  logic [N_GROUPS-1:0][GROUP_BITS-1:0] en_arr;
  logic [N_GROUPS*GROUP_BITS-1:0]      stat_flat;
  logic [N_GROUPS-1:0] stat_clr_oh, en_set_oh, en_clr_oh, eoi_oh;
  reg_kind_e           rd_kind;
  logic [GIW-1:0]      rd_grp;
  logic [DATA_W-1:0]   rd_val;
  logic                rvalid_q;
  logic [DATA_W-1:0]   rdata_q;

  msi_doorbell #(
    .N_GROUPS(N_GROUPS), .GROUP_BITS(GROUP_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dbl (
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data), .set_arr(set_arr)
  );

  msi_csr_decode #(
    .N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EOI_BIAS(EOI_BIAS)
  ) u_dec (
    .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .stat_clr_oh(stat_clr_oh), .en_set_oh(en_set_oh),
    .en_clr_oh(en_clr_oh), .eoi_oh(eoi_oh), .rd_kind(rd_kind), .rd_grp(rd_grp)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
    msi_group #(.GROUP_BITS(GROUP_BITS)) u_grp (
      .clk(clk), .rst_n(rst_n), .set_bits(set_arr[g]), .clr_we(stat_clr_oh[g]),
      .en_set_we(en_set_oh[g]), .en_clr_we(en_clr_oh[g]),
      .wbits(csr_wdata[GROUP_BITS-1:0]), .eoi(eoi_oh[g]),
      .status_o(stat_arr[g]), .enable_o(en_arr[g]), .irq_o(irq_o[g])
    );
  end

  assign stat_flat = stat_arr;

  always_comb begin
    rd_val = '0;
    unique case (rd_kind)
      KIND_STAT:              rd_val = DATA_W'(stat_arr[rd_grp]);
      KIND_ENSET, KIND_ENCLR: rd_val = DATA_W'(en_arr[rd_grp]);
      default:                rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= csr_valid && !csr_write;
      if (csr_valid && !csr_write) rdata_q <= rd_val;
    end
  end

  assign csr_rvalid = rvalid_q;
  assign csr_rdata  = rdata_q;
endmodule

// File: rtl/msi_agg_chk.sv
module msi_agg_chk
  import msi_agg_pkg::*;
#(
  parameter int N_GROUPS   = 8,
  parameter int GROUP_BITS = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int EOI_BIAS   = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           msi_valid,
  input logic [ADDR_W-1:0]              msi_addr,
  input logic [DATA_W-1:0]              msi_data,
  input logic                           csr_valid,
  input logic                           csr_write,
  input logic [ADDR_W-1:0]              csr_addr,
  input logic [DATA_W-1:0]              csr_wdata,
  input logic                           csr_rvalid,
  input logic [N_GROUPS-1:0]            irq_o,
  input logic [N_GROUPS*GROUP_BITS-1:0] stat_flat
);
  localparam int NUM_VEC = N_GROUPS * GROUP_BITS;
  localparam int GIW = $clog2(N_GROUPS);
  localparam int BIW = $clog2(GROUP_BITS);
  localparam int FIW = $clog2(NUM_VEC);

  logic                good_dbl, bad_dbl;
  logic [N_GROUPS-1:0] eoi_now;
  logic                eoi_prev;
  logic                dbl_q;
  logic [FIW-1:0]      dbl_idx_q;

  assign good_dbl = msi_valid && (msi_addr == ADDR_W'(DOORBELL_OFS))
                    && (msi_data < DATA_W'(NUM_VEC));
  assign bad_dbl  = msi_valid && !good_dbl;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_eoi
    assign eoi_now[g] = csr_valid && csr_write && (csr_addr == ADDR_W'(EOI_OFS))
                        && (csr_wdata == DATA_W'(g + EOI_BIAS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_prev  <= 1'b0;
      dbl_q     <= 1'b0;
      dbl_idx_q <= '0;
    end else begin
      eoi_prev  <= |eoi_now;
      dbl_q     <= good_dbl;
      dbl_idx_q <= FIW'(msi_data[GIW-1:0]) * FIW'(GROUP_BITS) + FIW'(msi_data[GIW +: BIW]);
    end
  end

  // R10
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !csr_write) |=> csr_rvalid);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_valid && !csr_write) |=> !csr_rvalid);

  // R9
  dbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_q |-> stat_flat[dbl_idx_q]);

  // R3
  bad_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_dbl && !csr_valid && !eoi_prev) |=> $stable(irq_o));

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_line
    // R8
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_now[g] |=> !irq_o[g]);
    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o[g]) |-> $past(csr_valid && csr_write));
  end
endmodule

bind msi_agg msi_agg_chk #(
  .N_GROUPS(N_GROUPS), .GROUP_BITS(GROUP_BITS), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .EOI_BIAS(EOI_BIAS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
  .msi_data(msi_data), .csr_valid(csr_valid), .csr_write(csr_write),
  .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rvalid(csr_rvalid),
  .irq_o(irq_o), .stat_flat(stat_flat)
);

// File: tb/msi_agg_tb_top.sv
module msi_agg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic [11:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        csr_valid = 1'b0;
  logic        csr_write = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_rvalid;
  logic [31:0] csr_rdata;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_agg dut_i (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .csr_valid(csr_valid), .csr_write(csr_write),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rvalid(csr_rvalid),
    .csr_rdata(csr_rdata), .irq_o(irq_o)
  );

  function automatic logic [11:0] a_stat(int g);  return 12'(32'h104 + 16*g); endfunction
  function automatic logic [11:0] a_enset(int g); return 12'(32'h108 + 16*g); endfunction
  function automatic logic [11:0] a_enclr(int g); return 12'(32'h10C + 16*g); endfunction

  task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read responses appear
  always @(negedge clk) begin
    if (rst_n && csr_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1, 0, "R10 unexpected read response");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(csr_rdata, e, t);
      end
    end
  end

  task automatic csr_wr(logic [11:0] a, logic [31:0] d);
    csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_valid = 1'b0; csr_write = 1'b0;
  endtask

  task automatic csr_rd(logic [11:0] a, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    csr_valid = 1'b1; csr_write = 1'b0; csr_addr = a;
    @(negedge clk);
    csr_valid = 1'b0;
  endtask

  task automatic msi_wr(logic [11:0] a, logic [31:0] d);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(irq_o, 8'h00, "R1 irq low in reset");
    chk(csr_rvalid, 0, "R1 rvalid low in reset");
    rst_n = 1'b1;
    idle(1);
    for (int g = 0; g < 8; g++) begin
      csr_rd(a_stat(g), 0, "R1 pending zero after reset");
      csr_rd(a_enset(g), 0, "R1 enable zero after reset");
    end
    idle(1);
    chk(csr_rvalid, 0, "R10 rvalid low when idle");

    msi_wr(12'h054, 13);
    chk(irq_o, 8'h00, "R7 masked vector raises no line");
    csr_rd(a_stat(5), 32'h2, "R2 R6 vector 13 raw pending");

    csr_wr(a_enset(5), 32'h2);
    chk(irq_o, 8'h20, "R7 enable raises line 5");
    csr_rd(a_enset(5), 32'h2, "R5 enable-set read");
    csr_rd(a_enclr(5), 32'h2, "R5 enable-clear read");
    csr_wr(a_enset(5), 32'h0);
    csr_rd(a_enset(5), 32'h2, "R5 zero set bits no effect");
    csr_wr(a_enset(5), 32'h5);
    csr_rd(a_enset(5), 32'h7, "R5 multi-bit set");
    csr_wr(a_enclr(5), 32'h5);
    csr_rd(a_enclr(5), 32'h2, "R5 multi-bit clear");
    csr_wr(a_enclr(5), 32'h0);
    csr_rd(a_enset(5), 32'h2, "R5 zero clear bits no effect");
    chk(irq_o, 8'h20, "R7 line 5 held");

    msi_wr(12'h054, 40);
    msi_wr(12'h058, 3);
    chk(irq_o, 8'h20, "R3 ignored doorbells leave lines");
    for (int g = 0; g < 8; g++)
      csr_rd(a_stat(g), (g == 5) ? 32'h2 : 32'h0, "R3 ignored doorbells set nothing");

    csr_wr(12'h050, 9);
    chk(irq_o, 8'h00, "R8 eoi drops line 5");
    idle(1);
    chk(irq_o, 8'h20, "R8 line 5 returns after eoi");
    csr_wr(12'h050, 2);
    chk(irq_o, 8'h20, "R8 reserved eoi code no effect");
    idle(1);
    chk(irq_o, 8'h20, "R8 reserved eoi code no effect later");
    csr_wr(12'h050, 12);
    chk(irq_o, 8'h20, "R8 out of range eoi code no effect");

    csr_wr(a_stat(5), 32'h0);
    csr_rd(a_stat(5), 32'h2, "R4 zero clear bits no effect");
    csr_wr(a_stat(5), 32'h2);
    chk(irq_o, 8'h00, "R7 line drops after clear");
    csr_rd(a_stat(5), 32'h0, "R4 pending cleared");

    csr_wr(a_enset(0), 32'hF);
    msi_valid = 1'b1; msi_addr = 12'h054; msi_data = 0;
    csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a_stat(0); csr_wdata = 32'h1;
    @(negedge clk);
    msi_valid = 1'b0; csr_valid = 1'b0; csr_write = 1'b0;
    chk(irq_o, 8'h01, "R9 collision leaves line high");
    csr_rd(a_stat(0), 32'h1, "R9 doorbell wins over clear");

    msi_wr(12'h054, 31);
    csr_wr(a_enset(7), 32'h8);
    chk(irq_o, 8'h81, "R7 vector 31 raises line 7");
    msi_wr(12'h054, 24);
    msi_wr(12'h054, 7);
    csr_rd(a_stat(7), 32'h9, "R2 vectors 7 and 31");
    csr_rd(a_stat(0), 32'h9, "R2 vectors 0 and 24");

    csr_wr(a_enclr(0), 32'hF);
    chk(irq_o, 8'h80, "R7 masking drops line 0");
    csr_rd(a_stat(0), 32'h9, "R6 masked pending still readable");

    idle(2);
    chk(exp_q.size(), 0, "R10 every read answered");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule